// File: doc/BRIEF.md
# DSHOT Frame PWM Transmitter

This block drives one output line toward a motor speed controller with a digital throttle stream that repeats without end. Every frame holds sixteen data slots followed by a run of empty slots. The data slots carry an 11-bit throttle or command value, a telemetry request bit and a 4-bit checksum. Each slot has the same length. A bit's value is given by how long the line stays high at the start of its slot: a long pulse is a one and a short pulse is a zero.

Software or a controller writes an 11-bit value with a one-clock write strobe. The value waits in a shadow register and is only copied into the transmit word when a new frame begins, so a frame never carries a mix of old and new bits. The slot length is the integer quotient of the clock frequency and the bit rate; both are parameters. A parameter picks one of two high-time ratio pairs, and another sets how many empty slots follow the data. A one-clock `frame_start` pulse marks the first slot of every frame.

Top module: `dshot_tx`

## Requirements
- R1: Data slots 0 to 10 carry the value with its most significant bit first. Slot 11 carries the telemetry bit. Slots 12 to 15 carry the checksum with its most significant bit first.
- R2: The checksum is the XOR of the three nibbles of the 12-bit word {value, telemetry bit}, which equals that word XOR itself shifted right by 4 XOR itself shifted right by 8, keeping bits 3:0.
- R3: The telemetry bit is always sent as 0.
- R4: With RATIO_ALT = 0, a one-slot is high for floor(P*72/100) clocks and a zero-slot for floor(P*37/100) clocks, where P is the slot length in clocks. The high time starts at the first clock of the slot and the line stays low for the rest of the slot.
- R5: With RATIO_ALT = 1, the high times are floor(P*71/100) clocks for a one and floor(P*39/100) clocks for a zero.
- R6: After the 16 data slots the line stays low for GAP_SLOTS empty slots (6 by default). The next frame starts directly after them.
- R7: P = CLK_HZ / BIT_RATE, using integer division, so a frame lasts (16 + GAP_SLOTS) * P clocks.
- R8: Values 0 to 47 (commands) are sent unchanged, just like throttle values of 48 and above.
- R9: A value written while a frame is in progress does not change that frame. It is sent from the next frame onward.
- R10: A write whose strobe is high two or more clocks before a `frame_start` pulse is used in the frame that pulse opens. A write in the clock just before the pulse waits one more frame.
- R11: `frame_start` is high for exactly one clock per frame, in the first clock of slot 0.
- R12: While the synchronous active-high reset is asserted, the line and `frame_start` are low and the stored value is cleared to 0. The first frame after release carries value 0, and its `frame_start` comes in the second clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-clock strobe that writes `wr_value` |
| wr_value | input | 11 | Throttle or command value |
| line_out | output | 1 | Pulse-width coded output line |
| frame_start | output | 1 | One-clock marker for the first slot of a frame |

## Verification
The value is exercised with all zeros, all ones, the two alternating-bit patterns, the lowest throttle value and a small command code. All zeros and all ones reveal stuck pulse widths. The alternating patterns reveal bit-order or slot-offset errors and produce differing checksums. The command code shows that no clamping takes place. Writes are placed in the middle of a frame, two clocks before a frame boundary and one clock before it, which separates a correct shadow latch from one that loads early or late. A second instance built with the alternative ratio and the longer gap checks the parameter variants, and a reset in the middle of a frame shows that the line drops and the stored value clears.

// File: rtl/dshot_tx_pkg.sv
package dshot_tx_pkg;

    localparam int DATA_SLOTS = 16;
    localparam int VALUE_W    = 11;

    function automatic logic [3:0] frame_crc(input logic [VALUE_W-1:0] value, input logic tele);
        logic [11:0] w;
        w = {value, tele};
        return w[3:0] ^ w[7:4] ^ w[11:8];
    endfunction

    function automatic logic [DATA_SLOTS-1:0] frame_word(input logic [VALUE_W-1:0] value);
        return {value, 1'b0, frame_crc(value, 1'b0)};
    endfunction

endpackage

// File: rtl/dshot_slot_timer.sv
module dshot_slot_timer #(
    parameter int PERIOD = 80
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [$clog2(PERIOD)-1:0] cnt,
    output logic                      last
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] CNT_MAX = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt == CNT_MAX) t_d.cnt = '0;
        else                    t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q.cnt <= CNT_MAX;
        else     t_q <= t_d;
    end

    assign cnt  = t_q.cnt;
    assign last = (t_q.cnt == CNT_MAX);

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        t_q.cnt <= CNT_MAX);

    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

endmodule

// File: rtl/dshot_frame_seq.sv
module dshot_frame_seq
    import dshot_tx_pkg::*;
#(
    parameter int GAP_SLOTS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               last,
    input  logic               wr_en,
    input  logic [VALUE_W-1:0] wr_value,
    output logic               data_slot,
    output logic               bit_val,
    output logic               frame_first
);
    localparam int TOTAL = DATA_SLOTS + GAP_SLOTS;
    localparam int SW    = $clog2(TOTAL);
    localparam logic [SW-1:0] SLOT_MAX  = SW'(TOTAL - 1);
    localparam logic [SW-1:0] DATA_LIM  = SW'(DATA_SLOTS);

    typedef struct packed {
        logic [SW-1:0]         slot;
        logic [VALUE_W-1:0]    shadow;
        logic [DATA_SLOTS-1:0] word;
    } seq_t;

    seq_t s_d, s_q;
    logic wrap;
    logic [3:0] bit_idx;

    assign wrap = last && (s_q.slot == SLOT_MAX);

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.shadow = wr_value;
        if (last) begin
            if (s_q.slot == SLOT_MAX) begin
                s_d.slot = '0;
                s_d.word = frame_word(wr_en ? wr_value : s_q.shadow);
            end else begin
                s_d.slot = s_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.slot   <= SLOT_MAX;
            s_q.shadow <= '0;
            s_q.word   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_idx     = 4'd15 - s_q.slot[3:0];
    assign data_slot   = (s_q.slot < DATA_LIM);
    assign bit_val     = data_slot && s_q.word[bit_idx];
    assign frame_first = (s_q.slot == '0);

    a_r6_slot_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.slot <= SLOT_MAX);

    a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(s_q.word));

    a_r3_tele_zero: assert property (@(posedge clk) disable iff (rst)
        (s_q.slot == SW'(11)) |-> !bit_val);

endmodule

// File: rtl/dshot_pulse_shaper.sv
module dshot_pulse_shaper #(
    parameter int PERIOD    = 80,
    parameter bit RATIO_ALT = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(PERIOD)-1:0] cnt,
    input  logic                      data_slot,
    input  logic                      bit_val,
    input  logic                      frame_first,
    output logic                      line_out,
    output logic                      frame_start
);
    localparam int CW = $clog2(PERIOD);
    localparam int HI_ONE  = RATIO_ALT ? (PERIOD * 71) / 100 : (PERIOD * 72) / 100;
    localparam int HI_ZERO = RATIO_ALT ? (PERIOD * 39) / 100 : (PERIOD * 37) / 100;
    localparam logic [CW-1:0] THR_ONE  = CW'(HI_ONE);
    localparam logic [CW-1:0] THR_ZERO = CW'(HI_ZERO);

    typedef struct packed {
        logic line;
        logic fs;
    } shp_t;

    shp_t p_d, p_q;
    logic [CW-1:0] thr;

    always_comb begin
        thr      = bit_val ? THR_ONE : THR_ZERO;
        p_d.line = data_slot && (cnt < thr);
        p_d.fs   = frame_first && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign line_out    = p_q.line;
    assign frame_start = p_q.fs;

    a_r6_gap_low: assert property (@(posedge clk) disable iff (rst)
        !data_slot |=> !line_out);

    a_r11_fs_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r4_one_pulse: assert property (@(posedge clk) disable iff (rst)
        (!line_out && (cnt != '0)) |=> !line_out);

    a_r4_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(line_out) |-> (cnt == CW'(1)));

endmodule

// File: rtl/dshot_tx.sv
module dshot_tx
    import dshot_tx_pkg::*;
#(
    parameter int CLK_HZ    = 48_000_000,
    parameter int BIT_RATE  = 600_000,
    parameter bit RATIO_ALT = 1'b0,
    parameter int GAP_SLOTS = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [10:0] wr_value,
    output logic        line_out,
    output logic        frame_start
);
    localparam int PERIOD = CLK_HZ / BIT_RATE;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          last;
    logic          data_slot;
    logic          bit_val;
    logic          frame_first;

    dshot_slot_timer #(.PERIOD(PERIOD)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt),
        .last (last)
    );

    dshot_frame_seq #(.GAP_SLOTS(GAP_SLOTS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .last        (last),
        .wr_en       (wr_en),
        .wr_value    (wr_value),
        .data_slot   (data_slot),
        .bit_val     (bit_val),
        .frame_first (frame_first)
    );

    dshot_pulse_shaper #(.PERIOD(PERIOD), .RATIO_ALT(RATIO_ALT)) u_shaper (
        .clk         (clk),
        .rst         (rst),
        .cnt         (cnt),
        .data_slot   (data_slot),
        .bit_val     (bit_val),
        .frame_first (frame_first),
        .line_out    (line_out),
        .frame_start (frame_start)
    );

    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!line_out && !frame_start));

endmodule

// File: tb/tb_dshot_tx.sv
module tb_dshot_tx;

    localparam int CLK_HZ = 15_000_000;
    localparam int RATE   = 300_000;
    localparam int P      = CLK_HZ / RATE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [10:0] wr_value = '0;
    logic        line_a, fs_a, line_b, fs_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int hi_cnt [32];
    bit shape_ok, fs_single_ok, fs_next_ok;

    always #5 clk = ~clk;

    dshot_tx #(.CLK_HZ(CLK_HZ), .BIT_RATE(RATE), .RATIO_ALT(1'b0), .GAP_SLOTS(6)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_value(wr_value),
        .line_out(line_a), .frame_start(fs_a)
    );

    dshot_tx #(.CLK_HZ(CLK_HZ), .BIT_RATE(RATE), .RATIO_ALT(1'b1), .GAP_SLOTS(14)) dut_alt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_value(wr_value),
        .line_out(line_b), .frame_start(fs_b)
    );

    function automatic bit lsig(input bit alt);
        return alt ? line_b : line_a;
    endfunction

    function automatic bit fsig(input bit alt);
        return alt ? fs_b : fs_a;
    endfunction

    function automatic int slots_of(input bit alt);
        return alt ? 30 : 22;
    endfunction

    function automatic logic [15:0] expect_bits(input logic [10:0] v);
        logic [11:0] w;
        logic [3:0]  c;
        w = {v, 1'b0};
        c = 4'h0;
        for (int k = 0; k < 3; k++) c = c ^ w[k*4 +: 4];
        return {v, 1'b0, c};
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Called at a negedge; records one frame starting at the next frame_start.
    task automatic capture(input bit alt, input int wr_at, input logic [10:0] wv);
        int n;
        bit seen_low;
        n = slots_of(alt) * P;
        for (int s = 0; s < 32; s++) hi_cnt[s] = 0;
        shape_ok = 1'b1; fs_single_ok = 1'b1; fs_next_ok = 1'b1;
        seen_low = 1'b0;
        while (!fsig(alt)) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i % P == 0) seen_low = 1'b0;
            if (lsig(alt)) begin
                hi_cnt[i / P]++;
                if (seen_low) shape_ok = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            if ((i > 0) && fsig(alt)) fs_single_ok = 1'b0;
            if (i == wr_at) begin
                wr_en = 1'b1; wr_value = wv;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        if (!fsig(alt)) fs_next_ok = 1'b0;
    endtask

    task automatic check_frame(input bit alt, input logic [10:0] v, input string tag);
        int t1, t0, e, bad_s, bad_a, bad_e;
        bit ok;
        logic [15:0] w;
        w  = expect_bits(v);
        t1 = alt ? (P * 71) / 100 : (P * 72) / 100;
        t0 = alt ? (P * 39) / 100 : (P * 37) / 100;
        // R1 value bits
        ok = 1'b1; bad_s = 0; bad_a = 0; bad_e = 0;
        for (int s = 0; s < 11; s++) begin
            e = w[15 - s] ? t1 : t0;
            if (ok && hi_cnt[s] != e) begin ok = 1'b0; bad_s = s; bad_a = hi_cnt[s]; bad_e = e; end
        end
        check(ok, $sformatf("R1 value slot %0d (%s)", bad_s, tag), bad_a, bad_e);
        // R3 telemetry slot
        check(hi_cnt[11] == t0, $sformatf("R3 telemetry slot (%s)", tag), hi_cnt[11], t0);
        // R2 checksum
        ok = 1'b1; bad_s = 0; bad_a = 0; bad_e = 0;
        for (int s = 12; s < 16; s++) begin
            e = w[15 - s] ? t1 : t0;
            if (ok && hi_cnt[s] != e) begin ok = 1'b0; bad_s = s; bad_a = hi_cnt[s]; bad_e = e; end
        end
        check(ok, $sformatf("R2 checksum slot %0d (%s)", bad_s, tag), bad_a, bad_e);
        // R4 pulse shape: single high run from slot start
        check(shape_ok, $sformatf("R4 high run at slot start (%s)", tag), shape_ok, 1);
        // R5 ratio set of the alternative instance
        if (alt) begin
            ok = 1'b1; bad_a = 0;
            for (int s = 0; s < 16; s++)
                if (ok && hi_cnt[s] != 35 && hi_cnt[s] != 19) begin ok = 1'b0; bad_a = hi_cnt[s]; end
            check(ok, $sformatf("R5 alternative widths (%s)", tag), bad_a, 35);
        end
        // R6 empty slots low
        ok = 1'b1; bad_a = 0;
        for (int s = 16; s < slots_of(alt); s++)
            if (hi_cnt[s] != 0) begin ok = 1'b0; bad_a = hi_cnt[s]; end
        check(ok, $sformatf("R6 empty slots low (%s)", tag), bad_a, 0);
        // R11 single frame_start, R7 frame length
        check(fs_single_ok, $sformatf("R11 one frame_start per frame (%s)", tag), fs_single_ok, 1);
        check(fs_next_ok, $sformatf("R7 next frame after %0d clocks (%s)", slots_of(alt) * P, tag),
              fs_next_ok, 1);
    endtask

    task automatic run_frame(input bit alt, input int wr_at, input logic [10:0] wv,
                             input logic [10:0] expv, input string tag);
        capture(alt, wr_at, wv);
        check_frame(alt, expv, tag);
    endtask

    task automatic release_and_sync(input string tag);
        rst = 1'b0;
        @(negedge clk);
        check(fs_a == 1'b0, {"R12 no frame_start one clock after release ", tag}, fs_a, 0);
        @(negedge clk);
        check(fs_a == 1'b1, {"R12 frame_start two clocks after release ", tag}, fs_a, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!line_a && !fs_a && !line_b && !fs_b, "R12 outputs low in reset",
                  {line_a, fs_a, line_b, fs_b}, 0);
        end
        release_and_sync("start");
        run_frame(1'b0, -1, 11'd0, 11'd0, "R12 first frame value 0");
    endtask

    task automatic t_patterns;
        run_frame(1'b0, 300, 11'd48, 11'd0, "R9 old value during write");
        run_frame(1'b0, -1, 11'd0, 11'd48, "lowest throttle 48");
        run_frame(1'b0, 500, 11'h7FF, 11'd48, "R9 old value kept");
        run_frame(1'b0, 700, 11'h555, 11'h7FF, "all ones");
        run_frame(1'b0, 100, 11'h2AA, 11'h555, "pattern 0x555");
        run_frame(1'b0, 900, 11'd1046, 11'h2AA, "pattern 0x2AA");
        run_frame(1'b0, -1, 11'd0, 11'd1046, "value 1046");
    endtask

    task automatic t_command;
        run_frame(1'b0, 40, 11'd5, 11'd1046, "R9 hold before command");
        run_frame(1'b0, -1, 11'd0, 11'd5, "R8 command 5 unchanged");
    endtask

    task automatic t_boundary;
        int n;
        n = 22 * P;
        run_frame(1'b0, n - 2, 11'd300, 11'd5, "R10 write two clocks early");
        run_frame(1'b0, -1, 11'd0, 11'd300, "R10 early write applied");
        run_frame(1'b0, n - 1, 11'd777, 11'd300, "R10 write one clock early");
        run_frame(1'b0, -1, 11'd0, 11'd300, "R10 late write deferred");
        run_frame(1'b0, -1, 11'd0, 11'd777, "R10 late write applied");
    endtask

    task automatic t_alt;
        capture(1'b1, -1, 11'd0);
        run_frame(1'b1, 200, 11'd1234, 11'd777, "R5 R6 alt old value");
        run_frame(1'b1, -1, 11'd0, 11'd1234, "R5 R6 alt new value");
    endtask

    task automatic t_reset_mid;
        capture(1'b0, -1, 11'd0);
        run_frame(1'b0, -1, 11'd0, 11'd1234, "shared write seen");
        for (int i = 0; i < 3; i++) @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!line_a && !fs_a, "R12 line low in mid-frame reset", {line_a, fs_a}, 0);
        end
        release_and_sync("mid-frame");
        run_frame(1'b0, -1, 11'd0, 11'd0, "R12 value cleared by reset");
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_patterns;
        t_command;
        t_boundary;
        t_alt;
        t_reset_mid;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule